// File: doc/BRIEF.md
# NAND Flash Device-Side Bus Front End

This block sits on the device side of a multiplexed NAND flash parallel bus. It samples the active-low chip enable, write enable, read enable and write protect strobes, the command and address latch selects, and an 8- or 16-bit I/O port through two-flop synchronizers. Every write-enable rising edge becomes a command, address or write-data event for the flash core. Which kind of event it becomes depends on the two latch selects at that edge.

The block counts address cycles after each command. The first two address cycles build a column address and the cycles after them build a row address. Each read-enable falling edge returns the core's word for the current column on the port and advances the column by one.

A busy timer loads one of three programmable cycle counts, for read, program or erase, when the core requests it. While it runs, the block pulls the open-drain ready/busy line low. Write protect inhibits program and erase. Chip enable high while the block is ready gives a standby status, and busy suppresses that status.

Top module: `nand_bus_front`

## Requirements
- R1: With chip enable low, command select high and address select low, a write-enable rising edge loads io_i[7:0] into cmd_o, pulses cmd_valid_o and resets the address cycle count to zero.
- R2: With address select high and command select low, each write-enable rising edge is one address cycle. Cycle 0 loads col_o[7:0]. Cycle 1 loads col_o[COL_W-1:8] from the low bits of the byte. Cycles 2 to ROW_BYTES+1 load row_o bytes 0 upward. Later cycles change nothing.
- R3: With both selects low, a write-enable rising edge loads the whole io_i word into wdata_o and pulses wdata_valid_o.
- R4: With chip enable low and the block ready, each read-enable falling edge loads rd_data_i, which is the core's word for the current col_o, into io_o and then increments col_o by one.
- R5: While chip enable is high, write-enable and read-enable edges produce no event and change no command, address, data or column state.
- R6: For command and address cycles only io_i[7:0] is used. The upper bits of a 16-bit port have no effect on cmd_o, col_o or row_o.
- R7: A busy request with busy_kind_i 0 (read), 1 (program) or 2 or 3 (erase) holds rb_pull_o high for exactly the selected nonzero cycle count. done_o then pulses for one cycle.
- R8: While write protect is low, pe_reset_o is high. A program or erase request then pulses done_o in the next cycle and never raises rb_pull_o. Read requests are unaffected.
- R9: standby_o is high when chip enable is high and the block is not busy. It is low in every busy cycle and returns once busy ends with chip enable still high.
- R10: A busy request that arrives while busy is ignored and does not lengthen the busy period.
- R11: io_oe_o is high only while both chip enable and read enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable strobe, active low |
| re_ni | input | 1 | Read enable strobe, active low |
| wp_ni | input | 1 | Write protect, active low |
| cmd_latch_i | input | 1 | Command latch select |
| addr_latch_i | input | 1 | Address latch select |
| io_i | input | IO_W | I/O port input side |
| io_o | output | IO_W | I/O port output side |
| io_oe_o | output | 1 | I/O port output enable |
| rd_data_i | input | IO_W | Core data for the current column |
| cmd_valid_o | output | 1 | Command event pulse |
| cmd_o | output | 8 | Last command byte |
| addr_valid_o | output | 1 | Address cycle event pulse |
| col_o | output | COL_W | Column address counter |
| row_o | output | 8*ROW_BYTES | Row address |
| wdata_valid_o | output | 1 | Write data event pulse |
| wdata_o | output | IO_W | Last write data word |
| busy_req_i | input | 1 | Busy period request from the core |
| busy_kind_i | input | 2 | 0 read, 1 program, 2 or 3 erase |
| rd_cycles_i | input | CNT_W | Read busy length |
| prog_cycles_i | input | CNT_W | Program busy length |
| erase_cycles_i | input | CNT_W | Erase busy length |
| rb_pull_o | output | 1 | Drive ready/busy low when high (open drain) |
| done_o | output | 1 | Busy period completed pulse |
| standby_o | output | 1 | Standby status |
| pe_reset_o | output | 1 | Program/erase machinery held in reset |

## Verification
The bench builds the block with IO_W=16, COL_W=12 and ROW_BYTES=2. The wide port puts nonzero upper bytes on command and address cycles, so the bench can show that those bits are dropped. The two-byte row lets a short sequence reach the point where extra address cycles saturate. The busy lengths are 5, 3 and 7 cycles, one value per operation kind, so the bench can count each busy period exactly and tell the three kinds apart.

// File: rtl/nfb_pkg.sv
package nfb_pkg;
  typedef enum logic [1:0] {
    BUSY_READ  = 2'd0,
    BUSY_PROG  = 2'd1,
    BUSY_ERASE = 2'd2
  } busy_kind_e;
endpackage

// File: rtl/nfb_sync.sv
module nfb_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/nfb_decode.sv
module nfb_decode #(
  parameter int unsigned IO_W      = 8,
  parameter int unsigned COL_W     = 12,
  parameter int unsigned ROW_BYTES = 3,
  localparam int unsigned ROW_W    = 8 * ROW_BYTES,
  localparam int unsigned LAST_CYC = ROW_BYTES + 2,
  localparam int unsigned ACW      = $clog2(LAST_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_s_i,
  input  logic             we_s_i,
  input  logic             re_s_i,
  input  logic             cle_s_i,
  input  logic             ale_s_i,
  input  logic [IO_W-1:0]  io_s_i,
  input  logic             busy_i,
  input  logic [IO_W-1:0]  rd_data_i,
  output logic [IO_W-1:0]  io_o,
  output logic             io_oe_o,
  output logic             cmd_valid_o,
  output logic [7:0]       cmd_o,
  output logic             addr_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             wdata_valid_o,
  output logic [IO_W-1:0]  wdata_o
);
  logic we_q, re_q;
  logic we_rise, re_fall, live;
  logic cmd_hit, adr_hit, dat_hit, rd_step;
  logic [ACW-1:0]   acyc_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_s_i;
      re_q <= re_s_i;
    end
  end

  assign we_rise = we_s_i & ~we_q;
  assign re_fall = ~re_s_i & re_q;
  assign live    = ~ce_s_i;
  assign cmd_hit = live & we_rise &  cle_s_i & ~ale_s_i;
  assign adr_hit = live & we_rise & ~cle_s_i &  ale_s_i;
  assign dat_hit = live & we_rise & ~cle_s_i & ~ale_s_i;
  assign rd_step = live & re_fall & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o   <= 1'b0;
      addr_valid_o  <= 1'b0;
      wdata_valid_o <= 1'b0;
      cmd_o         <= '0;
      wdata_o       <= '0;
      acyc_q        <= '0;
    end else begin
      cmd_valid_o   <= cmd_hit;
      addr_valid_o  <= adr_hit;
      wdata_valid_o <= dat_hit;
      if (cmd_hit) begin
        cmd_o  <= io_s_i[7:0];
        acyc_q <= '0;
      end else if (adr_hit && acyc_q < ACW'(LAST_CYC)) begin
        acyc_q <= acyc_q + ACW'(1);
      end
      if (dat_hit) wdata_o <= io_s_i;
    end
  end

  // column: two address cycles, then stepped by read strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
    end else if (adr_hit && acyc_q == ACW'(0)) begin
      col_q <= {col_q[COL_W-1:8], io_s_i[7:0]};
    end else if (adr_hit && acyc_q == ACW'(1)) begin
      col_q <= {io_s_i[COL_W-9:0], col_q[7:0]};
    end else if (rd_step) begin
      col_q <= col_q + COL_W'(1);
    end
  end

  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q[8*b +: 8] <= '0;
      end else if (adr_hit && acyc_q == ACW'(b + 2)) begin
        row_q[8*b +: 8] <= io_s_i[7:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      io_o <= '0;
    else if (rd_step) io_o <= rd_data_i;
  end

  assign io_oe_o = ~ce_s_i & ~re_s_i;
  assign col_o   = col_q;
  assign row_o   = row_q;

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, addr_valid_o, wdata_valid_o})); // R1
  AST_CE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_s_i |=> !(cmd_valid_o || addr_valid_o || wdata_valid_o)); // R5
  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_step && !adr_hit) |=> col_q == $past(col_q) + COL_W'(1)); // R4
  AST_ACYC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acyc_q <= ACW'(LAST_CYC)); // R2
  AST_CMD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> acyc_q == '0); // R1
endmodule

// File: rtl/nfb_busy_timer.sv
module nfb_busy_timer
  import nfb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_s_i,
  input  logic             wp_s_i,
  input  logic             busy_req_i,
  input  logic [1:0]       busy_kind_i,
  input  logic [CNT_W-1:0] rd_cycles_i,
  input  logic [CNT_W-1:0] prog_cycles_i,
  input  logic [CNT_W-1:0] erase_cycles_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             standby_o,
  output logic             pe_reset_o
);
  busy_kind_e       kind;
  logic [CNT_W-1:0] sel_cnt, cnt_q;
  logic             busy_q, done_q, standby_q;
  logic             accept, inhibit;

  assign kind = busy_kind_e'(busy_kind_i);

  always_comb begin
    case (kind)
      BUSY_READ: sel_cnt = rd_cycles_i;
      BUSY_PROG: sel_cnt = prog_cycles_i;
      default:   sel_cnt = erase_cycles_i;
    endcase
  end

  assign accept  = busy_req_i & ~busy_q;
  assign inhibit = (kind != BUSY_READ) & ~wp_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (inhibit || sel_cnt == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= sel_cnt;
        end
      end else if (busy_q) begin
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // standby only when ready; the launch cycle counts as busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) standby_q <= 1'b0;
    else         standby_q <= ce_s_i & ~busy_q & ~accept;
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign standby_o  = standby_q;
  assign pe_reset_o = ~wp_s_i;

  AST_WP_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_req_i && !busy_q && busy_kind_i != 2'd0 && !wp_s_i) |=> (!busy_q && done_q)); // R8
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == CNT_W'(1)) |=> (!busy_q && done_q)); // R7
  AST_NO_STANDBY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !standby_q); // R9
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q > CNT_W'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1))); // R10
endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front #(
  parameter int unsigned IO_W      = 8,
  parameter int unsigned COL_W     = 12,
  parameter int unsigned ROW_BYTES = 3,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned ROW_W    = 8 * ROW_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic             re_ni,
  input  logic             wp_ni,
  input  logic             cmd_latch_i,
  input  logic             addr_latch_i,
  input  logic [IO_W-1:0]  io_i,
  output logic [IO_W-1:0]  io_o,
  output logic             io_oe_o,
  input  logic [IO_W-1:0]  rd_data_i,
  output logic             cmd_valid_o,
  output logic [7:0]       cmd_o,
  output logic             addr_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             wdata_valid_o,
  output logic [IO_W-1:0]  wdata_o,
  input  logic             busy_req_i,
  input  logic [1:0]       busy_kind_i,
  input  logic [CNT_W-1:0] rd_cycles_i,
  input  logic [CNT_W-1:0] prog_cycles_i,
  input  logic [CNT_W-1:0] erase_cycles_i,
  output logic             rb_pull_o,
  output logic             done_o,
  output logic             standby_o,
  output logic             pe_reset_o
);
  logic [3:0]      strb_s;
  logic [1:0]      sel_s;
  logic [IO_W-1:0] io_s;
  logic            busy;

  nfb_sync #(.W(4), .RST_VAL(4'b1111)) u_sync_strb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({ce_ni, we_ni, re_ni, wp_ni}), .q_o(strb_s)
  );

  nfb_sync #(.W(2), .RST_VAL(2'b00)) u_sync_sel (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({cmd_latch_i, addr_latch_i}), .q_o(sel_s)
  );

  nfb_sync #(.W(IO_W), .RST_VAL('0)) u_sync_io (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(io_i), .q_o(io_s)
  );

  nfb_decode #(.IO_W(IO_W), .COL_W(COL_W), .ROW_BYTES(ROW_BYTES)) u_decode (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ce_s_i(strb_s[3]), .we_s_i(strb_s[2]), .re_s_i(strb_s[1]),
    .cle_s_i(sel_s[1]), .ale_s_i(sel_s[0]), .io_s_i(io_s),
    .busy_i(busy), .rd_data_i(rd_data_i),
    .io_o(io_o), .io_oe_o(io_oe_o),
    .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o),
    .addr_valid_o(addr_valid_o), .col_o(col_o), .row_o(row_o),
    .wdata_valid_o(wdata_valid_o), .wdata_o(wdata_o)
  );

  nfb_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ce_s_i(strb_s[3]), .wp_s_i(strb_s[0]),
    .busy_req_i(busy_req_i), .busy_kind_i(busy_kind_i),
    .rd_cycles_i(rd_cycles_i), .prog_cycles_i(prog_cycles_i),
    .erase_cycles_i(erase_cycles_i),
    .busy_o(busy), .done_o(done_o), .standby_o(standby_o),
    .pe_reset_o(pe_reset_o)
  );

  assign rb_pull_o = busy;

  AST_OD_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_pull_o |-> !standby_o); // R9
endmodule

// File: tb/nand_bus_front_test.sv
`timescale 1ns/1ps
module nand_bus_front_test;
  localparam int IO_W = 16, COL_W = 12, ROW_BYTES = 2, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic [IO_W-1:0] io_in = '0, io_out, rd_data, wdata;
  logic io_oe, cmd_v, addr_v, wdata_v, rb, done, stby, pe_rst;
  logic [7:0] cmd;
  logic [COL_W-1:0] col;
  logic [15:0] row;
  logic busy_req = 1'b0;
  logic [1:0] kind = 2'd0;
  int tests = 0, fails = 0, cmd_pulses = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign rd_data = {4'hA, col};

  nand_bus_front #(.IO_W(IO_W), .COL_W(COL_W), .ROW_BYTES(ROW_BYTES), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .re_ni(re_n), .wp_ni(wp_n),
    .cmd_latch_i(cle), .addr_latch_i(ale), .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe),
    .rd_data_i(rd_data), .cmd_valid_o(cmd_v), .cmd_o(cmd), .addr_valid_o(addr_v),
    .col_o(col), .row_o(row), .wdata_valid_o(wdata_v), .wdata_o(wdata),
    .busy_req_i(busy_req), .busy_kind_i(kind), .rd_cycles_i(16'd5),
    .prog_cycles_i(16'd3), .erase_cycles_i(16'd7), .rb_pull_o(rb), .done_o(done),
    .standby_o(stby), .pe_reset_o(pe_rst)
  );

  always @(posedge clk) if (cmd_v) cmd_pulses++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 command, 1 address, 2 data
  task automatic bus_write(input logic [1:0] k, input logic [IO_W-1:0] v);
    cle = (k == 2'd0); ale = (k == 2'd1); io_in = v;
    wait_clk(2); we_n = 1'b0; wait_clk(4); we_n = 1'b1; wait_clk(5);
  endtask

  task automatic rd_pulse();
    re_n = 1'b0; wait_clk(5);
  endtask

  task automatic run_busy(input logic [1:0] k, output int n);
    @(negedge clk); kind = k; busy_req = 1'b1;
    @(negedge clk); busy_req = 1'b0;
    n = 0;
    while (rb && n < 100) begin n++; @(negedge clk); end
  endtask

  typedef struct packed { logic [1:0] k; logic [15:0] io; logic [31:0] exp; } vec_t;
  localparam vec_t VECS [10] = '{
    '{2'd0, 16'h0080, 32'h0000_0080},  // R1
    '{2'd1, 16'hAB34, 32'h0000_0034},  // R2 R6
    '{2'd1, 16'h0012, 32'h0000_0234},  // R2
    '{2'd1, 16'h00C5, 32'h00C5_0234},  // R2
    '{2'd1, 16'h0007, 32'h07C5_0234},  // R2
    '{2'd2, 16'hBEEF, 32'h0000_BEEF},  // R3
    '{2'd2, 16'h1234, 32'h0000_1234},  // R3
    '{2'd0, 16'hFF70, 32'h0000_0070},  // R1 R6
    '{2'd1, 16'h0099, 32'h07C5_0299},  // R1 count reset
    '{2'd1, 16'h0001, 32'h07C5_0199}   // R2
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] obs;
    logic [COL_W-1:0] c0;
    wait_clk(3);
    chk("reset R1 cmd", 32'(cmd), 32'h0);
    chk("reset R4 col", 32'(col), 32'h0);
    chk("reset R7 rb", 32'(rb), 32'h0);
    rst_n = 1'b1; wait_clk(2);
    ce_n = 1'b0; wait_clk(4);

    for (int i = 0; i < 10; i++) begin
      bus_write(VECS[i].k, VECS[i].io);
      case (VECS[i].k)
        2'd0: obs = 32'(cmd);
        2'd1: obs = {row, 4'h0, col};
        default: obs = 32'(wdata);
      endcase
      chk($sformatf("vec%0d R1/R2/R3/R6", i), obs, VECS[i].exp);
    end
    chk("R1 cmd pulses", 32'(cmd_pulses), 32'd2);

    // R2 saturation: cycles beyond row ignored
    bus_write(2'd1, 16'h0055); bus_write(2'd1, 16'h0066);
    chk("R2 beyond-row cycle", {row, 4'h0, col}, 32'h6655_0199);
    bus_write(2'd1, 16'h0077);
    chk("R2 saturated", {row, 4'h0, col}, 32'h6655_0199);

    // R4 / R11 read strobes
    chk("R11 oe idle", 32'(io_oe), 32'h0);
    for (int j = 0; j < 3; j++) begin
      c0 = col;
      rd_pulse();
      chk("R11 oe active", 32'(io_oe), 32'h1);
      chk("R4 data", 32'(io_out), {16'h0, 4'hA, c0});
      chk("R4 col step", 32'(col), 32'(c0 + 12'd1));
      re_n = 1'b1; wait_clk(5);
    end

    // R5 chip enable high
    ce_n = 1'b1; wait_clk(4);
    c0 = col;
    bus_write(2'd0, 16'h00EE);
    chk("R5 cmd kept", 32'(cmd), 32'h70);
    bus_write(2'd2, 16'h5A5A);
    chk("R5 wdata kept", 32'(wdata), 32'h1234);
    rd_pulse();
    chk("R5 col kept", 32'(col), 32'(c0));
    chk("R11 oe ce high", 32'(io_oe), 32'h0);
    re_n = 1'b1; wait_clk(5);

    // R9 standby, then suppressed by busy
    chk("R9 standby ready", 32'(stby), 32'h1);
    @(negedge clk); kind = 2'd0; busy_req = 1'b1;
    @(negedge clk); busy_req = 1'b0;
    chk("R9 no standby busy", 32'(stby), 32'h0);
    wait_clk(8);
    chk("R9 standby after busy", 32'(stby), 32'h1);
    ce_n = 1'b0; wait_clk(4);
    chk("R9 standby off", 32'(stby), 32'h0);

    // R7 busy lengths
    run_busy(2'd0, n); chk("R7 read len", 32'(n), 32'd5); chk("R7 read done", 32'(done), 32'h1);
    wait_clk(2);
    run_busy(2'd1, n); chk("R7 prog len", 32'(n), 32'd3); chk("R7 prog done", 32'(done), 32'h1);
    wait_clk(2);
    run_busy(2'd2, n); chk("R7 erase len", 32'(n), 32'd7);
    wait_clk(2);

    // R10 request during busy ignored
    @(negedge clk); kind = 2'd0; busy_req = 1'b1;
    @(negedge clk); busy_req = 1'b0;
    @(negedge clk); kind = 2'd2; busy_req = 1'b1;
    @(negedge clk); busy_req = 1'b0;
    n = 2;
    while (rb && n < 100) begin n++; @(negedge clk); end
    chk("R10 busy not extended", 32'(n), 32'd5);
    wait_clk(3);
    chk("R10 no second busy", 32'(rb), 32'h0);

    // R8 write protect
    wp_n = 1'b0; wait_clk(4);
    chk("R8 pe reset", 32'(pe_rst), 32'h1);
    run_busy(2'd1, n); chk("R8 prog inhibited", 32'(n), 32'd0);
    chk("R8 prog done", 32'(done), 32'h1);
    wait_clk(2);
    run_busy(2'd3, n); chk("R8 erase inhibited", 32'(n), 32'd0);
    wait_clk(2);
    run_busy(2'd0, n); chk("R8 read allowed", 32'(n), 32'd5);
    wp_n = 1'b1; wait_clk(4);
    chk("R8 pe reset off", 32'(pe_rst), 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule